// File: doc/BRIEF.md
# Global-History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved outcomes across all branches, with 1 meaning taken and 0 meaning not taken. That history is XORed with a slice of the branch address to select one entry in a table of 2-bit saturating counters. The upper bit of the selected counter is the guess.

The fetch side presents a branch address on the lookup port and reads the guess combinationally in the same cycle. Later, the execute side reports the branch on the resolve port. It gives the address, the real outcome and the guess that was acted on. On that clock edge the consulted counter moves one step toward the real outcome, and the outcome enters the history. Because the table is indexed by history, repeating outcome patterns become predictable. A loop exit after a fixed trip count is one example.

Top module: `bp_twolevel`

## Requirements
- R1: After reset the history register is all zeros and every counter holds 1, so a lookup at any address predicts not taken (lk_taken = 0).
- R2: lk_taken is 1 exactly when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R3: A resolve with rs_taken = 1 raises the selected counter by one, and a counter at 3 stays at 3.
- R4: A resolve with rs_taken = 0 lowers the selected counter by one, and a counter at 0 stays at 0.
- R5: On each resolve the history shifts left by one, the oldest bit is lost and rs_taken enters bit 0. Without rs_valid the history and the table do not change.
- R6: The table index is history XOR address bits [HIST_W+1:2], with bits [1:0] treated as byte offset. Lookup and resolve use the same function.
- R7: The resolve index is formed from the history before that resolve's shift. A lookup in the same cycle as a resolve sees the table and history from before that edge.
- R8: resolve_miss is 1 exactly when rs_valid is 1 and rs_pred differs from rs_taken.
- R9: After warm-up, a single branch that repeats taken seven times and then not taken once is predicted with zero misses per period. The same holds for the repeating pattern taken, taken, not taken, taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | A branch is resolved this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_pred | input | 1 | Guess that was used for this branch |
| resolve_miss | output | 1 | Resolve carries a wrong guess |

## Verification
The bench first sweeps every table index after reset. It then drives one index through full climbs and descents, which separates correct saturation at both ends from wrap-around or skipped steps. A long pseudo-random run over addresses and outcomes compares every guess against an arithmetic model of history and counters. That run exposes index, shift-order and same-cycle ordering errors. The periodic loop patterns show whether history really disambiguates positions in the pattern: a predictor indexed by address alone must miss there.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef logic [1:0] bp_ctr_t;

   localparam bp_ctr_t CTR_MIN   = 2'd0;
   localparam bp_ctr_t CTR_MAX   = 2'd3;
   localparam bp_ctr_t CTR_RESET = 2'd1;

   // one saturating step toward the reported outcome
   function automatic bp_ctr_t ctr_step(input bp_ctr_t c, input logic up);
      bp_ctr_t r;
      if (up) r = (c == CTR_MAX) ? c : c + 2'd1;
      else    r = (c == CTR_MIN) ? c : c - 2'd1;
      return r;
   endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
   parameter int HIST_W = 8,
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter bit USE_PC = 1'b1
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [HIST_W-1:0] idx
);
   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;

   generate
      if (USE_PC) begin : g_xor
         assign idx = hist ^ pc[PC_LSB +: HIST_W];
      end else begin : g_hist_only
         assign idx = hist;
      end
   endgenerate
endmodule

// File: rtl/bp_history.sv
module bp_history #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) begin
         if (HIST_W == 1) hist <= shift_bit;
         else             hist <= {hist[HIST_W-2:0], shift_bit} ;
      end
   end

   assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));
   assert_hist_newbit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(shift_bit));
endmodule

// File: rtl/bp_pht.sv
module bp_pht
   import bp_pkg::*;
#(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_idx,
   input  logic              wr_taken
);
   localparam int DEPTH = 1 << HIST_W;

   bp_ctr_t tbl [DEPTH];
   bp_ctr_t wr_cur;

   assign rd_taken = tbl[rd_idx][1];
   assign wr_cur   = tbl[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_RESET;
      end else if (wr_en) begin
         tbl[wr_idx] <= ctr_step(wr_cur, wr_taken);
      end
   end

   assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && wr_cur != CTR_MAX) |=> tbl[$past(wr_idx)] == $past(wr_cur) + 2'd1);
   assert_ctr_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && wr_cur == CTR_MAX) |=> tbl[$past(wr_idx)] == CTR_MAX);
   assert_ctr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && wr_cur != CTR_MIN) |=> tbl[$past(wr_idx)] == $past(wr_cur) - 2'd1);
   assert_ctr_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && wr_cur == CTR_MIN) |=> tbl[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/bp_twolevel.sv
module bp_twolevel #(
   parameter int HIST_W = 8,
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter bit USE_PC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken,
   input  logic            rs_pred,
   output logic            resolve_miss
);
   generate
      if (HIST_W < 1 || HIST_W > 12) begin : g_bad_hist
         $error("bp_twolevel: HIST_W must lie in 1..12");
      end
      if (PC_LSB + HIST_W > PC_W) begin : g_bad_pc
         $error("bp_twolevel: PC_W too narrow for the index slice");
      end
   endgenerate

   logic [HIST_W-1:0] hist;
   logic [HIST_W-1:0] lk_idx;
   logic [HIST_W-1:0] rs_idx;

   bp_history #(.HIST_W(HIST_W)) hist_i (
      .clk(clk), .rst_n(rst_n),
      .shift_en(rs_valid), .shift_bit(rs_taken),
      .hist(hist)
   );

   bp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .USE_PC(USE_PC)) lk_hash_i (
      .pc(lk_pc), .hist(hist), .idx(lk_idx)
   );

   bp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .USE_PC(USE_PC)) rs_hash_i (
      .pc(rs_pc), .hist(hist), .idx(rs_idx)
   );

   bp_pht #(.HIST_W(HIST_W)) pht_i (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_taken(lk_taken),
      .wr_en(rs_valid), .wr_idx(rs_idx), .wr_taken(rs_taken)
   );

   assign resolve_miss = rs_valid & (rs_pred ^ rs_taken);

   // R7: same address and history on both ports means both hashes must agree
   always_comb begin
      if (rst_n && lk_pc == rs_pc)
         assert_same_index_R7: assert (lk_idx == rs_idx);
   end

   assert_miss_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_miss |-> rs_valid);
endmodule

// File: tb/bp_twolevel_tb_top.sv
`timescale 1ns/1ps
module bp_twolevel_tb_top;
   localparam int HW = 8;
   localparam int DEPTH = 1 << HW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;
   logic        rs_pred = 1'b0;
   logic        resolve_miss;

   int errors = 0;
   int checks = 0;

   int m_cnt [DEPTH];
   int m_hist;
   logic [31:0] lfsr = 32'hACE1_1234;

   always #2.5 clk = ~clk;

   bp_twolevel dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(lk_pc), .lk_taken(lk_taken),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_pred(rs_pred),
      .resolve_miss(resolve_miss)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int m_idx(input logic [31:0] pc);
      return m_hist ^ int'(pc[9:2]);
   endfunction

   function automatic int m_pred(input logic [31:0] pc);
      return (m_cnt[m_idx(pc)] >= 2) ? 1 : 0;
   endfunction

   function automatic logic [31:0] pc_for(input int idx);
      return 32'h0004_0000 | 32'((idx ^ m_hist) & (DEPTH-1)) << 2;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) m_cnt[i] = 1;
      m_hist = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rs_valid = 1'b0;
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one branch: lookup and resolve in the same cycle; returns 1 on a miss
   task automatic step(input logic [31:0] pc, input logic t, input logic flip,
                       input string req, output int miss);
      int ix;
      int exp_p;
      @(negedge clk);
      lk_pc = pc; rs_pc = pc; rs_valid = 1'b1; rs_taken = t;
      #1;
      exp_p = m_pred(pc);
      check(req, int'(lk_taken), exp_p);
      rs_pred = lk_taken ^ flip;
      #0.5;
      check("R8", int'(resolve_miss), int'(rs_pred != t));
      miss = int'(lk_taken != t);
      ix = m_idx(pc);
      @(posedge clk);
      if (t) m_cnt[ix] = (m_cnt[ix] == 3) ? 3 : m_cnt[ix] + 1;
      else   m_cnt[ix] = (m_cnt[ix] == 0) ? 0 : m_cnt[ix] - 1;
      m_hist = ((m_hist << 1) | int'(t)) & (DEPTH-1);
   endtask

   task automatic idle_look(input logic [31:0] pc, input string req);
      @(negedge clk);
      rs_valid = 1'b0; rs_taken = 1'b1;
      lk_pc = pc; rs_pc = pc;
      #1;
      check(req, int'(lk_taken), m_pred(pc));
      #0.5;
      check("R8", int'(resolve_miss), 0);
   endtask

   task automatic run_pattern(input logic [31:0] pc, input int period, input int pat,
                              input int warm, input int meas, input string req);
      int m;
      int misses;
      for (int p = 0; p < warm; p++)
         for (int k = 0; k < period; k++) step(pc, pat[period-1-k], 1'b0, req, m);
      for (int p = 0; p < meas; p++) begin
         misses = 0;
         for (int k = 0; k < period; k++) begin
            step(pc, pat[period-1-k], 1'b0, req, m);
            misses += m;
         end
         check(req, misses, 0);
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int m;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R6: every index predicts not taken after reset
      for (int i = 0; i < DEPTH; i++) idle_look(32'(i) << 2, "R1");

      // R3 then R4 on one index, including saturation at both ends (R2 via model)
      for (int n = 0; n < 5; n++) step(pc_for(37), 1'b1, 1'b0, "R3", m);
      idle_look(pc_for(37), "R3");
      for (int n = 0; n < 5; n++) step(pc_for(37), 1'b0, 1'b0, "R4", m);
      idle_look(pc_for(37), "R4");
      step(pc_for(37), 1'b1, 1'b0, "R4", m);
      step(pc_for(37), 1'b1, 1'b0, "R2", m);
      idle_look(pc_for(37), "R2");

      // R5: idle cycles leave history and table alone
      for (int i = 0; i < 16; i++) idle_look(32'(i * 7) << 2, "R5");

      // R5 / R6 / R7 / R8: random addresses and outcomes against the model
      for (int n = 0; n < 1500; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step({20'h0, lfsr[11:0]}, lfsr[17], lfsr[23], "R7", m);
         if (lfsr[5:0] == 6'd0) idle_look({20'h0, lfsr[19:8]}, "R5");
      end

      // R9: loop branch, taken seven times then not taken
      do_reset();
      run_pattern(32'h0000_1040, 8, 8'b1111_1110, 6, 4, "R9");
      // R9: taken, taken, not taken, taken
      do_reset();
      run_pattern(32'h0000_2210, 4, 4'b1101, 6, 4, "R9");

      @(negedge clk);
      rs_valid = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule